// File: doc/BRIEF.md
# Frozen Data Record Snapshot Window

This block sits between a producer that keeps refreshing a fixed-length data record and a byte-wide host bus that wants to read one complete, consistent copy of it. The producer marks the first byte of each record with a start strobe and delivers the rest as a stream of valid bytes. The host sees a small register window with two live offsets: one returns the next byte of the stored record, the other returns a status byte.

The host freezes the record by writing any value to the status offset. The freeze is honoured only at a record boundary. A record already being loaded is finished, and later records are dropped until the host writes any value to the data offset. The host polls busy until it reads 0, then reads bytes until not-empty drops, then clears the freeze. While the window is not frozen, every new record replaces the stored one and rewinds the host read pointer.

Top module: `rec_snapshot_fifo`

## Requirements
- R1: A read at offset 3 returns, one cycle later, a status byte with busy in bit 0, freeze in bit 1, not-empty in bit 2, and zeros in bits 7 to 3.
- R2: A write at offset 3 sets freeze and a write at offset 2 clears it, whatever the write data. Writes at offsets 0 and 1 change nothing.
- R3: A start byte that arrives while not frozen and not busy begins a record. Busy is 1 from the cycle after that byte until the last of the REC_LEN bytes (REC_LEN at least 2) is taken, and 0 from the cycle after that.
- R4: Not-empty becomes 1 in the cycle after a record's last byte. Reads at offset 2 then return the record bytes in arrival order, each one cycle after its read strobe.
- R5: Reading the last byte clears not-empty. A read at offset 2 while not-empty is 0 returns 0x00 and moves no pointer.
- R6: Once freeze is set, the record in progress still completes. Start bytes seen while frozen and not busy are dropped, and the stored record and the read position stay as they were.
- R7: After freeze is cleared, the next start byte begins a new record. That record overwrites storage, rewinds the read pointer to byte 0, and holds not-empty at 0 until it completes.
- R8: Producer bytes with valid set but no start, arriving while not busy, are ignored.
- R9: After reset, the status byte reads 0x00 and the read pointer is at byte 0.
- R10: A host data read in the same cycle as an accepted start byte returns the old stored byte at the current pointer. The new record's first host read then returns its byte 0.
- R11: Reads at offsets 0 and 1 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_start | input | 1 | Marks the current producer byte as byte 0 of a record |
| prod_valid | input | 1 | Producer byte is valid this cycle |
| prod_byte | input | 8 | Producer data byte |
| bus_addr | input | 2 | Host register offset |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe (data value irrelevant) |
| bus_rdata | output | 8 | Read result, valid the cycle after bus_rd, held until the next read |

## Verification
On every cycle the assertions check how the freeze flag follows host writes, that busy only rises through an accepted start, that a frozen idle window never starts loading, that not-empty only appears after a load and never while loading, and that empty reads and status padding return zeros. Only the bench scenarios can show the byte ordering of a stored record, the ignored records during a freeze, the pointer rewind, and the old-byte result of a read that collides with a record start.

// File: rtl/rsnap_pkg.sv
package rsnap_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 2;

  // Offsets the host decodes; their values are part of the register contract.
  localparam logic [OFS_W-1:0] OFS_DATA = 2'd2;
  localparam logic [OFS_W-1:0] OFS_STAT = 2'd3;

  // Status bit positions.
  localparam int ST_BUSY   = 0;
  localparam int ST_FREEZE = 1;
  localparam int ST_FILLED = 2;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_STAT = 2'd2
  } rsrc_e;
endpackage

// File: rtl/rsnap_ingest.sv
module rsnap_ingest
  import rsnap_pkg::*;
#(
  parameter int REC_LEN = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  prod_start,
  input  logic                                  prod_valid,
  input  logic [BYTE_W-1:0]                     prod_byte,
  input  logic                                  frozen,
  output logic                                  wr_en,
  output logic [((REC_LEN>1)?$clog2(REC_LEN):1)-1:0] wr_addr,
  output logic [BYTE_W-1:0]                     wr_data,
  output logic                                  busy,
  output logic                                  rec_start,
  output logic                                  rec_done
);
  localparam int AW = (REC_LEN > 1) ? $clog2(REC_LEN) : 1;
  localparam logic [AW-1:0] LAST = AW'(REC_LEN - 1);

  logic          busy_q;
  logic [AW-1:0] wptr_q;
  logic          take;

  // Freeze is only consulted here, at a record boundary.
  assign take      = prod_valid && prod_start && !busy_q && !frozen;
  assign rec_start = take;
  assign rec_done  = prod_valid && busy_q && (wptr_q == LAST);
  assign wr_en     = take || (prod_valid && busy_q);
  assign wr_addr   = busy_q ? wptr_q : '0;
  assign wr_data   = prod_byte;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wptr_q <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      wptr_q <= AW'(1);
    end else if (prod_valid && busy_q) begin
      if (wptr_q == LAST) begin
        busy_q <= 1'b0;
        wptr_q <= '0;
      end else begin
        wptr_q <= wptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsnap_store.sv
module rsnap_store
  import rsnap_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                                  clk,
  input  logic                                  we,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] wa,
  input  logic [BYTE_W-1:0]                     wd,
  input  logic                                  re,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] ra,
  output logic [BYTE_W-1:0]                     rq
);
  logic [BYTE_W-1:0] mem [DEPTH];

  // Simple dual port, synchronous read, read-before-write on collision.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/rsnap_hostif.sv
module rsnap_hostif
  import rsnap_pkg::*;
#(
  parameter int REC_LEN = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [OFS_W-1:0]                      bus_addr,
  input  logic                                  bus_rd,
  input  logic                                  bus_wr,
  input  logic                                  rec_start,
  input  logic                                  rec_done,
  input  logic                                  busy,
  input  logic [BYTE_W-1:0]                     mem_q,
  output logic                                  mem_rd_en,
  output logic [((REC_LEN>1)?$clog2(REC_LEN):1)-1:0] mem_rd_addr,
  output logic                                  frozen,
  output logic                                  not_empty,
  output logic [BYTE_W-1:0]                     bus_rdata
);
  localparam int AW = (REC_LEN > 1) ? $clog2(REC_LEN) : 1;
  localparam logic [AW-1:0] LAST = AW'(REC_LEN - 1);

  logic              frz_q;
  logic              filled_q;
  logic [AW-1:0]     rptr_q;
  rsrc_e             src_q;
  logic [BYTE_W-1:0] stat_q;
  logic              data_rd;
  logic              stat_rd;
  logic [BYTE_W-1:0] stat_now;

  assign data_rd     = bus_rd && (bus_addr == OFS_DATA);
  assign stat_rd     = bus_rd && (bus_addr == OFS_STAT);
  assign mem_rd_en   = data_rd && filled_q;
  assign mem_rd_addr = rptr_q;
  assign frozen      = frz_q;
  assign not_empty   = filled_q;

  always_comb begin
    stat_now            = '0;
    stat_now[ST_BUSY]   = busy;
    stat_now[ST_FREEZE] = frz_q;
    stat_now[ST_FILLED] = filled_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_q    <= 1'b0;
      filled_q <= 1'b0;
      rptr_q   <= '0;
      src_q    <= SRC_ZERO;
      stat_q   <= '0;
    end else begin
      if (bus_wr) begin
        if (bus_addr == OFS_STAT)      frz_q <= 1'b1;
        else if (bus_addr == OFS_DATA) frz_q <= 1'b0;
      end

      if (rec_start) begin
        filled_q <= 1'b0;
        rptr_q   <= '0;
      end else if (rec_done) begin
        filled_q <= 1'b1;
        rptr_q   <= '0;
      end else if (mem_rd_en) begin
        if (rptr_q == LAST) begin
          filled_q <= 1'b0;
          rptr_q   <= '0;
        end else begin
          rptr_q <= rptr_q + 1'b1;
        end
      end

      if (bus_rd) begin
        if (stat_rd)        src_q <= SRC_STAT;
        else if (mem_rd_en) src_q <= SRC_MEM;
        else                src_q <= SRC_ZERO;
      end
      if (stat_rd) stat_q <= stat_now;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_MEM:  bus_rdata = mem_q;
      SRC_STAT: bus_rdata = stat_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rec_snapshot_fifo.sv
module rec_snapshot_fifo
  import rsnap_pkg::*;
#(
  parameter int REC_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prod_start,
  input  logic              prod_valid,
  input  logic [BYTE_W-1:0] prod_byte,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [BYTE_W-1:0] bus_rdata
);
  localparam int AW = (REC_LEN > 1) ? $clog2(REC_LEN) : 1;

  logic              frz_w;
  logic              busy_w;
  logic              nempty_w;
  logic              start_w;
  logic              done_w;
  logic              we_w;
  logic [AW-1:0]     wa_w;
  logic [BYTE_W-1:0] wd_w;
  logic              re_w;
  logic [AW-1:0]     ra_w;
  logic [BYTE_W-1:0] rq_w;

  rsnap_ingest #(.REC_LEN(REC_LEN)) u_ingest (
    .clk(clk), .rst(rst),
    .prod_start(prod_start), .prod_valid(prod_valid), .prod_byte(prod_byte),
    .frozen(frz_w),
    .wr_en(we_w), .wr_addr(wa_w), .wr_data(wd_w),
    .busy(busy_w), .rec_start(start_w), .rec_done(done_w)
  );

  rsnap_store #(.DEPTH(REC_LEN)) u_store (
    .clk(clk),
    .we(we_w), .wa(wa_w), .wd(wd_w),
    .re(re_w), .ra(ra_w), .rq(rq_w)
  );

  rsnap_hostif #(.REC_LEN(REC_LEN)) u_host (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .rec_start(start_w), .rec_done(done_w), .busy(busy_w),
    .mem_q(rq_w), .mem_rd_en(re_w), .mem_rd_addr(ra_w),
    .frozen(frz_w), .not_empty(nempty_w), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/rsnap_chk.sv
module rsnap_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic       prod_start,
  input logic       prod_valid,
  input logic       busy,
  input logic       frozen,
  input logic       not_empty
);
  assert_status_pad_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> (bus_rdata[7:3] == 5'd0));

  assert_freeze_set_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd3) |=> frozen);

  assert_freeze_clr_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2) |=> !frozen);

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(prod_valid && prod_start && !frozen)) |=> !busy);

  assert_fill_after_load_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(not_empty) |-> $past(busy));

  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd2 && !not_empty) |=> (bus_rdata == 8'h00));

  assert_frozen_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (frozen && !busy) |=> !busy);

  assert_hidden_load_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !not_empty);
endmodule

bind rec_snapshot_fifo rsnap_chk u_chk (
  .clk(clk), .rst(rst),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
  .prod_start(prod_start), .prod_valid(prod_valid),
  .busy(busy_w), .frozen(frz_w), .not_empty(nempty_w)
);

// File: tb/sim_rec_snapshot_fifo.sv
`timescale 1ns/1ps
module sim_rec_snapshot_fifo;
  localparam int LEN = 16;
  localparam int NVEC = 13;
  // Entry: [11:10] op (0 read, 1 write), [9:8] offset, [7:0] expected read value.
  localparam logic [11:0] VEC [NVEC] = '{
    12'h304, 12'h700, 12'h306, 12'h2A0, 12'h2A1, 12'h000, 12'h100,
    12'h400, 12'h500, 12'h306, 12'h600, 12'h304, 12'h2A2
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       prod_start, prod_valid;
  logic [7:0] prod_byte;
  logic [1:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_rdata;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  rec_snapshot_fifo #(.REC_LEN(LEN)) u0 (
    .clk(clk), .rst(rst),
    .prod_start(prod_start), .prod_valid(prod_valid), .prod_byte(prod_byte),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] base, input int first, input int count, input bit with_start);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      prod_valid = 1'b1;
      prod_start = with_start && (i == 0);
      prod_byte  = base + 8'(first + i);
    end
    @(negedge clk);
    prod_valid = 1'b0;
    prod_start = 1'b0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    bus_read(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      report();
    end
  end

  initial begin
    rst = 1'b1; prod_start = 1'b0; prod_valid = 1'b0; prod_byte = 8'h00;
    bus_addr = 2'd0; bus_rd = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state, R5 empty read, R11 dead offsets
    expect_rd(2'd3, 8'h00, "R9 status after reset");
    expect_rd(2'd2, 8'h00, "R9 R5 data read when empty");
    expect_rd(2'd0, 8'h00, "R11 offset 0");
    expect_rd(2'd1, 8'h00, "R11 offset 1");

    // R8 bytes without a start are dropped
    send(8'h70, 0, 5, 1'b0);
    expect_rd(2'd3, 8'h00, "R8 stray bytes ignored");

    // R3 busy mid record, R4 filled after the last byte
    send(8'hA0, 0, 3, 1'b1);
    expect_rd(2'd3, 8'h01, "R3 busy during load");
    send(8'hA0, 3, LEN - 3, 1'b0);
    expect_rd(2'd3, 8'h04, "R3 R4 busy low, not-empty high");

    // Table: R1 status, R2 freeze commands, R4 ordered bytes, R11 dead offsets
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][11:10] == 2'd1) bus_write(VEC[i][9:8]);
      else expect_rd(VEC[i][9:8], VEC[i][7:0], "table R1 R2 R4 R11");
    end

    for (int k = 3; k < LEN; k++) expect_rd(2'd2, 8'hA0 + 8'(k), "R4 byte order");
    expect_rd(2'd3, 8'h00, "R5 not-empty cleared after last byte");
    expect_rd(2'd2, 8'h00, "R5 read past end");
    expect_rd(2'd3, 8'h00, "R5 no state change");

    // R6 freeze mid record: record completes, later record dropped
    send(8'hB0, 0, 4, 1'b1);
    bus_write(2'd3);
    send(8'hB0, 4, LEN - 4, 1'b0);
    expect_rd(2'd3, 8'h06, "R6 record finished under freeze");
    send(8'hE0, 0, LEN, 1'b1);
    expect_rd(2'd3, 8'h06, "R6 start ignored while frozen");
    expect_rd(2'd2, 8'hB0, "R6 stored record intact");
    expect_rd(2'd2, 8'hB1, "R6 stored record intact");

    // R7 unfreeze: new record replaces and rewinds
    bus_write(2'd2);
    send(8'hC0, 0, 5, 1'b1);
    expect_rd(2'd3, 8'h01, "R7 not-empty held low during load");
    send(8'hC0, 5, LEN - 5, 1'b0);
    expect_rd(2'd3, 8'h04, "R7 new record complete");
    expect_rd(2'd2, 8'hC0, "R7 pointer rewound");
    expect_rd(2'd2, 8'hC1, "R7 second byte");

    // R10 host read colliding with an accepted start
    begin
      logic [7:0] v;
      @(negedge clk);
      prod_valid = 1'b1; prod_start = 1'b1; prod_byte = 8'hD0;
      bus_addr = 2'd2;   bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; prod_valid = 1'b0; prod_start = 1'b0;
      v = bus_rdata;
      chk("R10 old byte on collision", v, 8'hC2);
    end
    send(8'hD0, 1, LEN - 1, 1'b0);
    expect_rd(2'd2, 8'hD0, "R10 new record starts at byte 0");

    finished = 1'b1;
    report();
  end
endmodule